// File: doc/BRIEF.md
# Addressable Cascadable Delay Line

This block is a bit-serial delay line built from a chain of sixteen-stage shift segments. Every rising clock edge that sees the shift enable high moves each stored bit one stage along, takes a new bit from the serial input into the first stage, and passes the last stage of each segment into the first stage of the next. While the enable is low, every stored bit holds.

A tap address picks the stage that drives the tap output. The lower four address bits pick a stage inside a segment and the upper bits pick the segment, so address A returns the bit accepted A+1 enabled edges ago. The tap is a pure multiplexer, so a new address shows a new stage at once, without waiting for a clock edge. A separate cascade output always presents the final stage of the last segment. It can feed the serial input of another delay line to make a longer one. Stored bits start at zero through their initial value. There is no functional reset.

Top module: `tap_delay_line`

## Requirements
- R1: With tap address A (0 to NUM_SEGS*16-1, default 0 to 127), `tapOut` equals the `serialIn` value accepted at the (A+1)-th most recent rising edge at which `shiftEn` was high. Address 0 therefore gives a delay of one enabled edge.
- R2: A rising edge with `shiftEn` low changes no stored bit, whatever `serialIn` carries.
- R3: `tapOut` follows `tapAddr` combinationally. After an address change with no clock edge in between, the output shows the newly addressed stage.
- R4: `cascadeOut` always presents the final stage of the last segment, which is the bit accepted NUM_SEGS*16 enabled edges ago (128 by default).
- R5: `tapAddr[3:0]` selects the stage inside a segment and `tapAddr[ADDR_W-1:4]` selects the segment. The last stage of segment k feeds the first stage of segment k+1 on the same enabled edge, so the delay is continuous across segment boundaries (addresses 15 to 16, 31 to 32, and so on).
- R6: Before any enabled edge, every stage reads 0 at `tapOut` for every address, and `cascadeOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stages move on its rising edge |
| shiftEn | input | 1 | Clock enable; high lets the stages advance |
| serialIn | input | 1 | Serial bit taken into the first stage |
| tapAddr | input | ADDR_W (7) | Tap selector: segment in the upper bits, stage in the lower four |
| tapOut | output | 1 | Combinational value of the addressed stage |
| cascadeOut | output | 1 | Final stage of the last segment, for chaining |

## Verification
A single 1 followed by zeros walks through the line, so each address position and every segment boundary can be seen to hold the bit at exactly one delay. A shift with an off-by-one or a broken link between segments shows up as a misplaced 1. A dense mixed pattern longer than the whole line checks the cascade output against the full-depth delay. A stretch with the enable low and a toggling serial input, followed by a scan of all addresses, separates a true hold from a leak. Several address changes inside one clock period, and a long run of random data, enables and addresses, compare every cycle against a queue model. These cover the combinational tap and enable patterns that the directed cases miss.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // Depth of one shift segment and the width of its local stage index.
  localparam int SEG_DEPTH = 16;
  localparam int SEG_AW    = $clog2(SEG_DEPTH);

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic              shift;     // advance every stage this edge
    logic [SEG_AW-1:0] localIdx;  // stage index inside the chosen segment
  } tdl_strobe_t;

endpackage

// File: rtl/tdl_segment.sv
module tdl_segment #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          shift,
  input  logic          serialIn,
  input  logic [AW-1:0] localIdx,
  output logic          tapOut,
  output logic          headOut,
  output logic          cascadeOut
);

  // Stored bits; stage 0 is the newest. Power-up value only, no reset.
  logic [DEPTH-1:0] stages = '0;

  always_ff @(posedge clk) begin
    if (shift) begin
      stages <= {stages[DEPTH-2:0], serialIn};
    end
  end

  assign tapOut     = stages[localIdx];
  assign headOut    = stages[0];
  assign cascadeOut = stages[DEPTH-1];

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!pastValid)
    !$past(shift) |-> $stable(stages)) else $error("segment moved while disabled"); // R2
  AST_SEG_ENTRY: assert property (@(posedge clk) disable iff (!pastValid)
    $past(shift) |-> (headOut == $past(serialIn))) else $error("entry stage wrong"); // R1
  AST_SEG_EXIT: assert property (@(posedge clk) disable iff (!pastValid)
    $past(shift) |-> (cascadeOut == $past(stages[DEPTH-2]))) else $error("exit stage wrong"); // R4

endmodule

// File: rtl/tdl_ctrl.sv
module tdl_ctrl
  import tdl_pkg::*;
#(
  parameter int NUM_SEGS = 8,
  localparam int TOTAL    = NUM_SEGS * SEG_DEPTH,
  localparam int ADDR_W   = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              shiftEn,
  input  logic [ADDR_W-1:0] tapAddr,
  output tdl_strobe_t       strobe,
  output logic [NUM_SEGS-1:0] segSel
);

  assign strobe.shift    = shiftEn;
  assign strobe.localIdx = tapAddr[SEG_AW-1:0];

  // Segment decode: one-hot on the upper address bits.
  generate
    if (NUM_SEGS == 1) begin : g_single
      assign segSel = 1'b1;
    end else begin : g_multi
      localparam int SIDX_W = ADDR_W - SEG_AW;
      logic [SIDX_W-1:0] segIdx;
      assign segIdx = tapAddr[ADDR_W-1:SEG_AW];
      for (genvar k = 0; k < NUM_SEGS; k++) begin : g_dec
        assign segSel[k] = (segIdx == SIDX_W'(k));
      end
    end
  endgenerate

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!pastValid)
    ({1'b0, tapAddr} < (ADDR_W+1)'(TOTAL)) |-> ($countones(segSel) == 1))
    else $error("segment select not one-hot"); // R5

endmodule

// File: rtl/tdl_datapath.sv
module tdl_datapath
  import tdl_pkg::*;
#(
  parameter int NUM_SEGS = 8
) (
  input  logic                clk,
  input  tdl_strobe_t         strobe,
  input  logic [NUM_SEGS-1:0] segSel,
  input  logic                serialIn,
  output logic                tapOut,
  output logic                cascadeOut
);

  logic [NUM_SEGS:0]   link;     // link[k] feeds segment k
  logic [NUM_SEGS-1:0] segTaps;
  logic [NUM_SEGS-1:0] segHeads;

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  assign link[0] = serialIn;

  generate
    for (genvar k = 0; k < NUM_SEGS; k++) begin : g_seg
      tdl_segment #(.DEPTH(SEG_DEPTH)) u_seg (
        .clk       (clk),
        .shift     (strobe.shift),
        .serialIn  (link[k]),
        .localIdx  (strobe.localIdx),
        .tapOut    (segTaps[k]),
        .headOut   (segHeads[k]),
        .cascadeOut(link[k+1])
      );
      if (k > 0) begin : g_link_chk
        AST_SEG_LINK: assert property (@(posedge clk) disable iff (!pastValid)
          $past(strobe.shift) |-> (segHeads[k] == $past(link[k])))
          else $error("segment link broken"); // R5
      end
    end
  endgenerate

  assign tapOut     = |(segTaps & segSel);
  assign cascadeOut = link[NUM_SEGS];

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import tdl_pkg::*;
#(
  parameter int NUM_SEGS = 8,
  localparam int ADDR_W  = $clog2(NUM_SEGS * SEG_DEPTH)
) (
  input  logic              clk,
  input  logic              shiftEn,
  input  logic              serialIn,
  input  logic [ADDR_W-1:0] tapAddr,
  output logic              tapOut,
  output logic              cascadeOut
);

  tdl_strobe_t         strobe;
  logic [NUM_SEGS-1:0] segSel;

  tdl_ctrl #(.NUM_SEGS(NUM_SEGS)) u_ctrl (
    .clk    (clk),
    .shiftEn(shiftEn),
    .tapAddr(tapAddr),
    .strobe (strobe),
    .segSel (segSel)
  );

  tdl_datapath #(.NUM_SEGS(NUM_SEGS)) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .segSel    (segSel),
    .serialIn  (serialIn),
    .tapOut    (tapOut),
    .cascadeOut(cascadeOut)
  );

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  AST_MIN_DELAY: assert property (@(posedge clk) disable iff (!pastValid)
    ($past(shiftEn) && (tapAddr == '0)) |-> (tapOut == $past(serialIn)))
    else $error("address 0 is not a one-edge delay"); // R1

endmodule

// File: tb/tap_delay_line_bench.sv
module tap_delay_line_bench;

  localparam int NUM_SEGS = 8;
  localparam int TOTAL    = NUM_SEGS * 16;
  localparam int ADDR_W   = $clog2(TOTAL);

  logic              clk = 1'b0;
  logic              shiftEn = 1'b0;
  logic              serialIn = 1'b0;
  logic [ADDR_W-1:0] tapAddr = '0;
  logic              tapOut;
  logic              cascadeOut;

  int checkCount = 0;
  int failCount  = 0;

  logic [TOTAL-1:0] model = '0;  // model[i]: bit accepted i+1 enabled edges ago

  always #5 clk = ~clk;

  tap_delay_line #(.NUM_SEGS(NUM_SEGS)) u_tap_delay_line (
    .clk(clk), .shiftEn(shiftEn), .serialIn(serialIn),
    .tapAddr(tapAddr), .tapOut(tapOut), .cascadeOut(cascadeOut)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // One clock with the given inputs; the model follows an enabled edge.
  task automatic tick(input logic en, input logic d);
    shiftEn  = en;
    serialIn = d;
    @(posedge clk);
    #1;
    if (en) model = {model[TOTAL-2:0], d};
  endtask

  task automatic readTap(input string req, input int a);
    tapAddr = ADDR_W'(a);
    #1;
    chk(req, $sformatf("tap addr %0d", a), tapOut, model[a]);
  endtask

  task automatic test_powerup();  // R6
    for (int a = 0; a < TOTAL; a++) begin
      tapAddr = ADDR_W'(a);
      #0.5;
      chk("R6", $sformatf("power-up tap %0d", a), tapOut, 1'b0);
    end
    chk("R6", "power-up cascade", cascadeOut, 1'b0);
  endtask

  task automatic test_walk_one();  // R5 and R1
    tick(1'b1, 1'b1);
    for (int k = 1; k <= 40; k++) begin
      for (int a = k - 2; a <= k; a++) begin
        if (a >= 0) begin
          tapAddr = ADDR_W'(a);
          #1;
          chk("R5", $sformatf("walk edge %0d addr %0d", k, a), tapOut, (a == k - 1));
        end
      end
      tick(1'b1, 1'b0);
    end
  endtask

  task automatic test_fill();  // R1 and R4
    for (int i = 0; i < TOTAL + 20; i++) begin
      tick(1'b1, logic'(((i * 7 + 3) % 5) < 2));
      readTap("R1", i % TOTAL);
      chk("R4", "cascade full depth", cascadeOut, model[TOTAL-1]);
    end
  endtask

  task automatic test_hold();  // R2
    for (int i = 0; i < 20; i++) begin
      tick(1'b0, logic'(i % 2));
      chk("R2", "cascade during hold", cascadeOut, model[TOTAL-1]);
    end
    shiftEn = 1'b0;
    for (int a = 0; a < TOTAL; a++) begin
      tapAddr = ADDR_W'(a);
      #0.5;
      chk("R2", $sformatf("held stage %0d", a), tapOut, model[a]);
    end
  endtask

  task automatic test_comb_addr();  // R3
    int addrs [6] = '{0, 127, 15, 16, 64, 3};
    tick(1'b0, 1'b0);
    for (int j = 0; j < 6; j++) begin
      tapAddr = ADDR_W'(addrs[j]);
      #1;
      chk("R3", $sformatf("no-edge address %0d", addrs[j]), tapOut, model[addrs[j]]);
    end
  endtask

  task automatic test_random();  // R1, R2, R4
    for (int i = 0; i < 1500; i++) begin
      logic en;
      int a;
      en = ($urandom % 4) != 0;
      tick(en, logic'($urandom % 2));
      a = int'($urandom % TOTAL);
      readTap("R1", a);
      chk("R4", "random cascade", cascadeOut, model[TOTAL-1]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #1;
    test_powerup();
    test_walk_one();
    test_fill();
    test_hold();
    test_comb_addr();
    test_random();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule